// File: doc/BRIEF.md
# Virtual-PC Indirect Branch Target Predictor

This block predicts where an indirect branch will go. It treats the branch as a short chain of virtual conditional branches. It evaluates them one per clock, using its own gshare-style table of 2-bit counters and its own tagged, direct-mapped target buffer. Each step works from a virtual PC and a virtual history. The virtual PC is the real PC XORed with a per-step hash constant. The virtual history is the global history shifted left by the step number, with zeros entering at the low end. The first step whose target buffer entry hits and whose counter says taken supplies the predicted target.

The fetch side issues a request carrying the PC and the global history. The block then holds `busy_o` until it pulses a result, which is either a target or no prediction. When the branch later resolves, the back end presents the PC, the history and the correct target on the resolve port. The block walks the same virtual PCs in order. The step that already holds the correct target is trained toward taken, and the steps before it are trained toward not-taken. If no step holds the correct target, the block allocates one for it.

Top module: `vpc_indirect_pred`

## Requirements
- R1: After reset `busy_o` and `pred_valid_o` are 0, every target buffer entry is invalid, and every direction counter holds 1 (weakly not-taken).
- R2: A request is taken only while `busy_o` is 0 and no resolve is presented in the same cycle. `busy_o` rises in the next cycle and stays high until the result. Requests presented while busy are ignored and produce no result.
- R3: Step k (k = 0..3) uses virtual PC = PC XOR C[k], with C = {16'h0000, 16'h5A3C, 16'hC3A5, 16'h96E1}. Its virtual history is the 8-bit global history shifted left by k, with zeros entering at the low end.
- R4: The direction counter used at step k is indexed by the low 6 bits of (virtual PC XOR virtual history). A counter value of 2 or 3 means taken.
- R5: The target buffer has 16 entries, indexed by virtual PC bits [3:0] and tagged with bits [15:4]. A hit requires the valid bit and a matching tag.
- R6: At each step of a prediction, the outcome is decided in this order:
  - a target buffer miss ends the walk with no prediction;
  - a hit with a taken counter ends it with that entry's target;
  - a hit with a not-taken counter moves on to the next step;
  - after step 3, the walk ends with no prediction.
- R7: The result appears as a one-cycle `pred_valid_o` pulse, with `pred_hit_o` and `pred_target_o`, exactly n cycles after acceptance, where n is the number of steps evaluated. `busy_o` falls in that same cycle.
- R8: A resolve is taken while idle and has priority over a simultaneous request. At each step, if the entry hits and its target equals the correct target, that step's counter increments (saturating at 3) and training ends. Otherwise the counter decrements (saturating at 0) and the walk continues. A resolve produces no `pred_valid_o`, and `busy_o` lasts k+1 cycles when the match is at step k.
- R9: If no step matches, one extra allocation cycle follows the four steps, so `busy_o` lasts 5 cycles. The correct target is written, tagged, into the entry of the first step whose entry had its valid bit clear, or into step 3's entry if every step's entry was valid. That step's counter is then set to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Prediction request |
| req_pc_i | input | 16 | PC of the indirect branch |
| req_hist_i | input | 8 | Global history for the request |
| rsv_valid_i | input | 1 | Resolve (training) request |
| rsv_pc_i | input | 16 | PC of the resolved branch |
| rsv_hist_i | input | 8 | Global history seen at prediction time |
| rsv_target_i | input | 16 | Correct target |
| busy_o | output | 1 | A walk is in progress |
| pred_valid_o | output | 1 | One-cycle result strobe |
| pred_hit_o | output | 1 | Result carries a target |
| pred_target_o | output | 16 | Predicted target |

## Verification
The bench builds the block with its default parameters: 16-bit PCs, 8-bit history, 64 direction counters, 16 target entries and four steps. Tables this small let a handful of branches alias in both arrays. Within a few dozen operations they also fill every step of one branch, which forces the last-step replacement path. A behavioural reference model predicts each operation's step count, and therefore the exact length of `busy_o`. It also predicts the result, so the bench checks the latency of every walk as well as the predicted targets.

// File: rtl/vpc_pkg.sv
`timescale 1ns/1ps
package vpc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRED, ST_TRAIN, ST_ALLOC} vpc_state_e;
  typedef enum logic [1:0] {CNT_HOLD, CNT_INC, CNT_DEC, CNT_SET_WT} cnt_op_e;

  // per-step hash constants; step 0 leaves the PC unchanged
  function automatic logic [15:0] hash_const(input int unsigned k);
    case (k)
      0:       return 16'h0000;
      1:       return 16'h5A3C;
      2:       return 16'hC3A5;
      default: return 16'h96E1;
    endcase
  endfunction
endpackage

// File: rtl/vpc_hash.sv
`timescale 1ns/1ps
module vpc_hash #(
  parameter int PC_W      = 16,
  parameter int HIST_W    = 8,
  parameter int DIR_IDX_W = 6,
  parameter int BTB_IDX_W = 4,
  parameter int MAX_ITER  = 4,
  localparam int ITER_W   = $clog2(MAX_ITER)
) (
  input  logic [PC_W-1:0]           pc_i,
  input  logic [HIST_W-1:0]         hist_i,
  input  logic [ITER_W-1:0]         iter_i,
  output logic [DIR_IDX_W-1:0]      dir_idx_o,
  output logic [BTB_IDX_W-1:0]      btb_idx_o,
  output logic [PC_W-BTB_IDX_W-1:0] btb_tag_o
);
  logic [PC_W-1:0]   const_tbl [MAX_ITER];
  logic [PC_W-1:0]   vpc;
  logic [HIST_W-1:0] vhist;

  for (genvar g = 0; g < MAX_ITER; g++) begin : g_const
    assign const_tbl[g] = PC_W'(vpc_pkg::hash_const(g));
  end

  assign vpc       = pc_i ^ const_tbl[iter_i];
  assign vhist     = hist_i << iter_i;
  assign dir_idx_o = vpc[DIR_IDX_W-1:0] ^ vhist[DIR_IDX_W-1:0];
  assign btb_idx_o = vpc[BTB_IDX_W-1:0];
  assign btb_tag_o = vpc[PC_W-1:BTB_IDX_W];
endmodule

// File: rtl/vpc_dir_table.sv
`timescale 1ns/1ps
module vpc_dir_table
  import vpc_pkg::*;
#(
  parameter int IDX_W  = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  cnt_op_e          op_i,
  output logic [1:0]       cnt_o
);
  logic [1:0] cnt_q [DEPTH];
  logic [1:0] cnt_d;

  assign cnt_o = cnt_q[idx_i];

  always_comb begin
    cnt_d = cnt_o;
    case (op_i)
      CNT_INC:    if (cnt_o != 2'd3) cnt_d = cnt_o + 2'd1;
      CNT_DEC:    if (cnt_o != 2'd0) cnt_d = cnt_o - 2'd1;
      CNT_SET_WT: cnt_d = 2'd2;
      default:    cnt_d = cnt_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= 2'd1;
    end else if (op_i != CNT_HOLD) begin
      cnt_q[idx_i] <= cnt_d;
    end
  end

  p_alloc_weak_taken_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_SET_WT) |=> cnt_q[$past(idx_i)] == 2'd2);
  p_dec_never_wraps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_DEC && cnt_o == 2'd0) |=> cnt_q[$past(idx_i)] == 2'd0);
endmodule

// File: rtl/vpc_btb.sv
`timescale 1ns/1ps
module vpc_btb #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 12,
  parameter int TGT_W  = 16,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             vld_o,
  output logic             hit_o,
  output logic [TGT_W-1:0] tgt_o,
  input  logic             we_i,
  input  logic [TGT_W-1:0] wtgt_i
);
  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TGT_W-1:0] tgt_q [DEPTH];

  assign vld_o = vld_q[idx_i];
  assign hit_o = vld_o && (tag_q[idx_i] == tag_i);
  assign tgt_o = tgt_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
      end
    end else if (we_i) begin
      vld_q[idx_i] <= 1'b1;
      tag_q[idx_i] <= tag_i;
      tgt_q[idx_i] <= wtgt_i;
    end
  end

  p_fill_sets_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vld_q[$past(idx_i)]);
endmodule

// File: rtl/vpc_indirect_pred.sv
`timescale 1ns/1ps
module vpc_indirect_pred
  import vpc_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int HIST_W    = 8,
  parameter int DIR_IDX_W = 6,
  parameter int BTB_IDX_W = 4,
  parameter int MAX_ITER  = 4,
  localparam int ITER_W   = $clog2(MAX_ITER),
  localparam int TAG_W    = PC_W - BTB_IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PC_W-1:0]   req_pc_i,
  input  logic [HIST_W-1:0] req_hist_i,
  input  logic              rsv_valid_i,
  input  logic [PC_W-1:0]   rsv_pc_i,
  input  logic [HIST_W-1:0] rsv_hist_i,
  input  logic [PC_W-1:0]   rsv_target_i,
  output logic              busy_o,
  output logic              pred_valid_o,
  output logic              pred_hit_o,
  output logic [PC_W-1:0]   pred_target_o
);
  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(MAX_ITER - 1);

  vpc_state_e        state_q;
  logic [ITER_W-1:0] iter_q, free_q;
  logic              free_ok_q;
  logic [PC_W-1:0]   pc_q, tgt_q;
  logic [HIST_W-1:0] hist_q;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [BTB_IDX_W-1:0] btb_idx;
  logic [TAG_W-1:0]     btb_tag;
  logic [1:0]           cnt;
  logic                 btb_vld, btb_hit, btb_we, tgt_eq, at_last;
  logic [PC_W-1:0]      btb_tgt;
  cnt_op_e              cnt_op;

  vpc_hash #(
    .PC_W(PC_W), .HIST_W(HIST_W), .DIR_IDX_W(DIR_IDX_W),
    .BTB_IDX_W(BTB_IDX_W), .MAX_ITER(MAX_ITER)
  ) u_hash (
    .pc_i(pc_q), .hist_i(hist_q), .iter_i(iter_q),
    .dir_idx_o(dir_idx), .btb_idx_o(btb_idx), .btb_tag_o(btb_tag)
  );

  vpc_dir_table #(.IDX_W(DIR_IDX_W)) u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(dir_idx), .op_i(cnt_op), .cnt_o(cnt)
  );

  vpc_btb #(.IDX_W(BTB_IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W)) u_btb (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(btb_idx), .tag_i(btb_tag),
    .vld_o(btb_vld), .hit_o(btb_hit), .tgt_o(btb_tgt),
    .we_i(btb_we), .wtgt_i(tgt_q)
  );

  assign at_last = (iter_q == LAST_ITER);
  assign tgt_eq  = btb_hit && (btb_tgt == tgt_q);
  assign btb_we  = (state_q == ST_ALLOC);
  assign busy_o  = (state_q != ST_IDLE);

  always_comb begin
    case (state_q)
      ST_TRAIN: cnt_op = tgt_eq ? CNT_INC : CNT_DEC;
      ST_ALLOC: cnt_op = CNT_SET_WT;
      default:  cnt_op = CNT_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      iter_q        <= '0;
      free_q        <= '0;
      free_ok_q     <= 1'b0;
      pc_q          <= '0;
      hist_q        <= '0;
      tgt_q         <= '0;
      pred_valid_o  <= 1'b0;
      pred_hit_o    <= 1'b0;
      pred_target_o <= '0;
    end else begin
      pred_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          iter_q    <= '0;
          free_ok_q <= 1'b0;
          if (rsv_valid_i) begin
            state_q <= ST_TRAIN;
            pc_q    <= rsv_pc_i;
            hist_q  <= rsv_hist_i;
            tgt_q   <= rsv_target_i;
          end else if (req_valid_i) begin
            state_q <= ST_PRED;
            pc_q    <= req_pc_i;
            hist_q  <= req_hist_i;
          end
        end
        ST_PRED: begin
          if (!btb_hit || cnt[1] || at_last) begin
            state_q       <= ST_IDLE;
            pred_valid_o  <= 1'b1;
            pred_hit_o    <= btb_hit && cnt[1];
            pred_target_o <= btb_tgt;
          end else begin
            iter_q <= iter_q + 1'b1;
          end
        end
        ST_TRAIN: begin
          if (tgt_eq) begin
            state_q <= ST_IDLE;
          end else begin
            if (!btb_vld && !free_ok_q) begin
              free_q    <= iter_q;
              free_ok_q <= 1'b1;
            end
            if (at_last) begin
              state_q <= ST_ALLOC;
              // slot for the new target: first empty step, else the last one
              iter_q  <= free_ok_q ? free_q : iter_q;
            end else begin
              iter_q <= iter_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_result_single_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |=> !pred_valid_o);
  p_result_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pred_valid_o) |-> ($past(busy_o) && !busy_o));
  p_resolve_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && rsv_valid_i) |=> (busy_o && !pred_valid_o));
  p_training_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TRAIN || state_q == ST_ALLOC) |=> !pred_valid_o);
  p_request_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> busy_o);
endmodule

// File: tb/sim_vpc_indirect_pred.sv
`timescale 1ns/1ps
module sim_vpc_indirect_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsv_valid = 1'b0;
  logic [15:0] req_pc = '0, rsv_pc = '0, rsv_tgt = '0;
  logic [7:0]  req_hist = '0, rsv_hist = '0;
  logic        busy, pv, phit;
  logic [15:0] ptgt;

  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  vpc_indirect_pred u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_pc_i(req_pc), .req_hist_i(req_hist),
    .rsv_valid_i(rsv_valid), .rsv_pc_i(rsv_pc), .rsv_hist_i(rsv_hist),
    .rsv_target_i(rsv_tgt),
    .busy_o(busy), .pred_valid_o(pv), .pred_hit_o(phit), .pred_target_o(ptgt)
  );

  // behavioural reference state
  int m_cnt [64];
  bit m_vld [16];
  int m_tag [16];
  int m_tgt [16];
  int hc [4] = '{32'h0000, 32'h5A3C, 32'hC3A5, 32'h96E1};

  function automatic int vpc_of(int pc, int k); return (pc ^ hc[k]) & 16'hFFFF; endfunction
  function automatic int didx(int pc, int h, int k);
    return (vpc_of(pc, k) ^ ((h << k) & 8'hFF)) & 63;
  endfunction
  function automatic bit bhit(int pc, int k);
    int v = vpc_of(pc, k);
    return m_vld[v & 15] && (m_tag[v & 15] == (v >> 4));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic wait_busy(int len, string req);
    for (int c = 0; c < len; c++) begin
      chk(busy === 1'b1, req, "busy during walk", int'(busy), 1);
      chk(pv === 1'b0, req, "no early result", int'(pv), 0);
      @(negedge clk);
    end
    chk(busy === 1'b0, req, "busy released", int'(busy), 0);
  endtask

  task automatic predict(int pc, int h);
    int len = 0, exp_hit = 0, exp_tgt = 0;
    for (int k = 0; k < 4; k++) begin
      len = k + 1;
      if (!bhit(pc, k)) break;
      if (m_cnt[didx(pc, h, k)] >= 2) begin
        exp_hit = 1; exp_tgt = m_tgt[vpc_of(pc, k) & 15]; break;
      end
    end
    req_pc = 16'(pc); req_hist = 8'(h); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_busy(len, "R7");
    chk(pv === 1'b1, "R7", "result strobe", int'(pv), 1);
    chk(phit === 1'(exp_hit), "R6", "hit flag", int'(phit), exp_hit);
    if (exp_hit != 0) chk(ptgt === 16'(exp_tgt), "R6", "target", int'(ptgt), exp_tgt);
  endtask

  // both=1 also raises a request that must lose to the resolve (R8) and,
  // held through the walk, must be ignored (R2)
  task automatic resolve(int pc, int h, int tgt, bit both);
    int len = 5, freek = -1, slot, v;
    bit matched = 0;
    for (int k = 0; k < 4; k++) begin
      int i = didx(pc, h, k);
      v = vpc_of(pc, k);
      if (bhit(pc, k) && m_tgt[v & 15] == tgt) begin
        if (m_cnt[i] < 3) m_cnt[i]++;
        len = k + 1; matched = 1; break;
      end
      if (m_cnt[i] > 0) m_cnt[i]--;
      if (!m_vld[v & 15] && freek < 0) freek = k;
    end
    if (!matched) begin
      slot = (freek >= 0) ? freek : 3;
      v = vpc_of(pc, slot);
      m_vld[v & 15] = 1; m_tag[v & 15] = v >> 4; m_tgt[v & 15] = tgt;
      m_cnt[didx(pc, h, slot)] = 2;
    end
    rsv_pc = 16'(pc); rsv_hist = 8'(h); rsv_tgt = 16'(tgt); rsv_valid = 1'b1;
    if (both) begin req_pc = 16'(pc); req_hist = 8'(h); req_valid = 1'b1; end
    @(negedge clk);
    rsv_valid = 1'b0;
    for (int c = 0; c < len; c++) begin
      chk(busy === 1'b1, matched ? "R8" : "R9", "busy during training", int'(busy), 1);
      chk(pv === 1'b0, "R8", "training gives no result", int'(pv), 0);
      if (c == len - 1) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(busy === 1'b0, matched ? "R8" : "R9", "training length", int'(busy), 0);
    chk(pv === 1'b0, "R2", "ignored request gives no result", int'(pv), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) m_cnt[i] = 1;
    for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(pv === 1'b0, "R1", "result after reset", int'(pv), 0);

    predict(16'h1234, 8'hFF);                 // R1/R5: empty buffer, one step
    resolve(16'h1234, 8'hFF, 16'hA000, 0);    // R9: allocate step 0
    predict(16'h1234, 8'hFF);                 // R4: counter 2, hit at step 0
    resolve(16'h1234, 8'hFF, 16'hB000, 0);    // R9: step 0 decremented, step 1 allocated
    predict(16'h1234, 8'hFF);                 // R3/R6: second step supplies target
    resolve(16'h1234, 8'hFF, 16'hC000, 0);
    resolve(16'h1234, 8'hFF, 16'hD000, 0);    // all four steps now filled
    predict(16'h1234, 8'hFF);
    resolve(16'h1234, 8'hFF, 16'hE000, 0);    // R9: replaces the last step
    predict(16'h1234, 8'hFF);
    resolve(16'h1234, 8'hFF, 16'hC000, 0);    // R8: match at a middle step
    predict(16'h1234, 8'hFF);
    predict(16'h1234, 8'h0F);                 // R4: different history, different counters
    resolve(16'h4000, 8'h00, 16'h0100, 1);    // R8/R2: resolve beats a request
    predict(16'h4000, 8'h00);

    for (int n = 0; n < 80; n++) begin
      int pcs [3] = '{16'h1234, 16'h4000, 16'h0BEE};
      int pc = pcs[$urandom_range(0, 2)];
      int h  = $urandom_range(0, 255);
      if ($urandom_range(0, 1) == 1)
        resolve(pc, h, 16'h8000 + 16'h10 * $urandom_range(0, 5), 1'($urandom_range(0, 3) == 0));
      else
        predict(pc, h);
    end
    finish_run();
  end
endmodule